// File: doc/BRIEF.md
# Multi-line interrupt vector arbiter

This block keeps the pending interrupt requests of up to sixteen serial lines. Each line has two request classes, receive and transmit. Each class has one bit per line. Per-line set pulses mark a line as pending. Per-line clear pulses and a per-line reset withdraw a request. For each class, a master request output is high while any line of that class is pending.

When the interrupt controller acknowledges a class, the arbiter does three things in the same cycle:
- It picks the lowest-numbered pending line of that class.
- It clears only that line's bit.
- It returns that line's own vector one cycle later. Each line has its own vector slot, eight apart. The transmit vector sits four above the receive vector of the same line.

The two classes are independent, so both can be acknowledged in the same cycle.

The vector outputs carry a one-cycle valid flag. They have no ready input and no back-pressure: every acknowledge produces exactly one valid vector on the following cycle, and the consumer must take it in that cycle. Register decoding and priority between devices are handled elsewhere.

Top module: `ivec_arbiter`

## Requirements
- R1: A set pulse on a line makes that line pending in its class, and the class master request is high from the next cycle.
- R2: A class master request stays high while at least one line of that class is pending. It goes low in the cycle after the last pending bit is removed, and stays low while no set pulse arrives.
- R3: An acknowledge of a class gives a valid pulse of exactly one cycle on that class's vector output in the next cycle. The vector belongs to the lowest-numbered line pending at the acknowledging edge.
- R4: The receive vector of line k is BASE + 8*k. The transmit vector is BASE + 8*k + 4. With the default BASE = 0x300 and a 12-bit vector: receive line 5 is 0x328, transmit line 0 is 0x304, and transmit line 15 is 0x37C.
- R5: The acknowledge clears the granted line's bit. All other pending bits of that class stay as they were.
- R6: An acknowledge when no line of the class is pending still gives the valid pulse, with a vector of 0.
- R7: A clear pulse removes that line's request in its class without producing a vector.
- R8: A line reset pulse removes both the receive and the transmit request of that line.
- R9: A set pulse for a line wins over a clear pulse, a line reset, or an acknowledge grant for the same line in the same cycle. The line stays pending.
- R10: Receive and transmit acknowledges in the same cycle are both serviced in that cycle, each on its own vector output.
- R11: After reset, no line is pending, both master requests are low, both valid flags are low and both vectors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_set | input | N_LINES | Per-line receive request set pulses |
| tx_set | input | N_LINES | Per-line transmit request set pulses |
| rx_clr | input | N_LINES | Per-line receive request clear pulses |
| tx_clr | input | N_LINES | Per-line transmit request clear pulses |
| line_rst | input | N_LINES | Per-line reset pulses, clearing both classes |
| rx_ack | input | 1 | Receive class acknowledge strobe |
| tx_ack | input | 1 | Transmit class acknowledge strobe |
| rx_req | output | 1 | Receive master request |
| tx_req | output | 1 | Transmit master request |
| rx_vec | output | VEC_W | Receive vector word |
| rx_vec_valid | output | 1 | Receive vector valid, one cycle per acknowledge |
| tx_vec | output | VEC_W | Transmit vector word |
| tx_vec_valid | output | 1 | Transmit vector valid, one cycle per acknowledge |

## Verification
The hardest case to reach from the ports is a set pulse that arrives on the same edge as an acknowledge granting that same line. The only visible evidence is that the master request stays high and a second acknowledge returns the same line again. The bench makes exactly one line pending and then drives the acknowledge and the set pulse for that line in one cycle. It then drains the class with further acknowledges, which shows that the bit survived. Pending state is observed throughout by draining with acknowledges until a zero vector comes back.

// File: rtl/ivarb_pkg.sv
package ivarb_pkg;
  typedef enum logic {CLS_RX = 1'b0, CLS_TX = 1'b1} req_class_e;
  localparam int unsigned SLOT_SHIFT = 3;
  localparam int unsigned TX_SLOT_OFFSET = 4;
  localparam int unsigned NUM_CLASSES = 2;
endpackage

// File: rtl/ivarb_lowest.sv
module ivarb_lowest #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ivarb_class.sv
module ivarb_class
  import ivarb_pkg::*;
#(
  parameter int unsigned N_LINES  = 16,
  parameter int unsigned VEC_W    = 12,
  parameter int unsigned VEC_BASE = 'h300,
  parameter req_class_e  CLS      = CLS_RX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] set_i,
  input  logic [N_LINES-1:0] clr_i,
  input  logic [N_LINES-1:0] lrst_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_vld_o
);
  localparam int unsigned IW  = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam int unsigned OFF = (CLS == CLS_TX) ? TX_SLOT_OFFSET : 0;

  logic [N_LINES-1:0] pend_q, pend_d, grant;
  logic               found;
  logic [IW-1:0]      win;
  logic [VEC_W-1:0]   win_vec;

  ivarb_lowest #(.N(N_LINES)) u_pick (
    .req   (pend_q),
    .found (found),
    .idx   (win)
  );

  always_comb begin
    grant = '0;
    if (ack_i && found) grant[win] = 1'b1;
  end

  // set has priority over every removal source
  assign pend_d  = (pend_q & ~(clr_i | lrst_i | grant)) | set_i;
  assign win_vec = VEC_W'(VEC_BASE) + (VEC_W'(win) << SLOT_SHIFT) + VEC_W'(OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      vec_vld_o <= ack_i;
      if (ack_i) vec_o <= found ? win_vec : '0;
    end
  end

  assign req_o = |pend_q;
endmodule

// File: rtl/ivec_arbiter.sv
module ivec_arbiter
  import ivarb_pkg::*;
#(
  parameter int unsigned N_LINES  = 16,
  parameter int unsigned VEC_W    = 12,
  parameter int unsigned VEC_BASE = 'h300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] rx_set,
  input  logic [N_LINES-1:0] tx_set,
  input  logic [N_LINES-1:0] rx_clr,
  input  logic [N_LINES-1:0] tx_clr,
  input  logic [N_LINES-1:0] line_rst,
  input  logic               rx_ack,
  input  logic               tx_ack,
  output logic               rx_req,
  output logic               tx_req,
  output logic [VEC_W-1:0]   rx_vec,
  output logic               rx_vec_valid,
  output logic [VEC_W-1:0]   tx_vec,
  output logic               tx_vec_valid
);
  logic [N_LINES-1:0] set_a [NUM_CLASSES];
  logic [N_LINES-1:0] clr_a [NUM_CLASSES];
  logic               ack_a [NUM_CLASSES];
  logic               req_a [NUM_CLASSES];
  logic               vld_a [NUM_CLASSES];
  logic [VEC_W-1:0]   vec_a [NUM_CLASSES];

  assign set_a[0] = rx_set;
  assign set_a[1] = tx_set;
  assign clr_a[0] = rx_clr;
  assign clr_a[1] = tx_clr;
  assign ack_a[0] = rx_ack;
  assign ack_a[1] = tx_ack;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    ivarb_class #(
      .N_LINES  (N_LINES),
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .CLS      ((c == 0) ? CLS_RX : CLS_TX)
    ) u_cls (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_a[c]),
      .clr_i     (clr_a[c]),
      .lrst_i    (line_rst),
      .ack_i     (ack_a[c]),
      .req_o     (req_a[c]),
      .vec_o     (vec_a[c]),
      .vec_vld_o (vld_a[c])
    );
  end

  assign rx_req       = req_a[0];
  assign tx_req       = req_a[1];
  assign rx_vec       = vec_a[0];
  assign tx_vec       = vec_a[1];
  assign rx_vec_valid = vld_a[0];
  assign tx_vec_valid = vld_a[1];
endmodule

// File: rtl/ivarb_chk.sv
module ivarb_chk #(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned VEC_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] rx_set,
  input logic [N_LINES-1:0] tx_set,
  input logic               rx_ack,
  input logic               tx_ack,
  input logic               rx_req,
  input logic               tx_req,
  input logic [VEC_W-1:0]   rx_vec,
  input logic               rx_vec_valid,
  input logic [VEC_W-1:0]   tx_vec,
  input logic               tx_vec_valid
);
  a_r1_rx_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set != '0) |=> rx_req);
  a_r1_tx_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_set != '0) |=> tx_req);
  a_r2_rx_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_req && rx_set == '0) |=> !rx_req);
  a_r2_tx_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req && tx_set == '0) |=> !tx_req);
  a_r3_rx_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |=> rx_vec_valid);
  a_r3_rx_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ack |=> !rx_vec_valid);
  a_r10_tx_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> tx_vec_valid);
  a_r10_tx_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ack |=> !tx_vec_valid);
  a_r4_rx_slot_align: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vec_valid && rx_vec != '0) |-> (rx_vec[2:0] == 3'd0));
  a_r4_tx_slot_align: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vec_valid && tx_vec != '0) |-> (tx_vec[2:0] == 3'd4));
  a_r6_rx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_req) |=> (rx_vec == '0));
  a_r6_tx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && !tx_req) |=> (tx_vec == '0));
endmodule

bind ivec_arbiter ivarb_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_set       (rx_set),
  .tx_set       (tx_set),
  .rx_ack       (rx_ack),
  .tx_ack       (tx_ack),
  .rx_req       (rx_req),
  .tx_req       (tx_req),
  .rx_vec       (rx_vec),
  .rx_vec_valid (rx_vec_valid),
  .tx_vec       (tx_vec),
  .tx_vec_valid (tx_vec_valid)
);

// File: tb/sim_ivec_arbiter.sv
`timescale 1ns/1ps
module sim_ivec_arbiter;
  localparam int N = 16;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rx_set = '0, tx_set = '0, rx_clr = '0, tx_clr = '0, line_rst = '0;
  logic rx_ack = 1'b0, tx_ack = 1'b0;
  logic rx_req, tx_req, rx_vec_valid, tx_vec_valid;
  logic [W-1:0] rx_vec, tx_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ivec_arbiter #(.N_LINES(N), .VEC_W(W), .VEC_BASE('h300)) u0 (.*);

  function automatic int rxv(int ln); return 'h300 + 8 * ln; endfunction
  function automatic int txv(int ln); return 'h300 + 8 * ln + 4; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one posedge with the given inputs; outputs checked at the following negedge
  task automatic step(logic [N-1:0] rs, logic [N-1:0] ts, logic [N-1:0] rc,
                      logic [N-1:0] tc, logic [N-1:0] lr, logic ra, logic ta);
    rx_set = rs; tx_set = ts; rx_clr = rc; tx_clr = tc; line_rst = lr;
    rx_ack = ra; tx_ack = ta;
    @(negedge clk);
    rx_set = '0; tx_set = '0; rx_clr = '0; tx_clr = '0; line_rst = '0;
    rx_ack = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic idle(); step('0, '0, '0, '0, '0, 1'b0, 1'b0); endtask

  task automatic t_reset();
    chk("R11 rx_req", int'(rx_req), 0);
    chk("R11 tx_req", int'(tx_req), 0);
    chk("R11 rx_valid", int'(rx_vec_valid), 0);
    chk("R11 tx_valid", int'(tx_vec_valid), 0);
    chk("R11 rx_vec", int'(rx_vec), 0);
    chk("R11 tx_vec", int'(tx_vec), 0);
  endtask

  task automatic t_single();
    step(N'(1) << 5, '0, '0, '0, '0, 1'b0, 1'b0);
    chk("R1 rx_req after set", int'(rx_req), 1);
    chk("R1 tx_req untouched", int'(tx_req), 0);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R3 rx valid", int'(rx_vec_valid), 1);
    chk("R4 rx vec line5", int'(rx_vec), rxv(5));
    chk("R5 req low after last grant", int'(rx_req), 0);
    idle();
    chk("R3 valid single cycle", int'(rx_vec_valid), 0);
  endtask

  task automatic t_priority();
    step((N'(1) << 9) | (N'(1) << 3) | (N'(1) << 12), '0, '0, '0, '0, 1'b0, 1'b0);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R3 lowest first", int'(rx_vec), rxv(3));
    chk("R2 req held", int'(rx_req), 1);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R5 next lowest", int'(rx_vec), rxv(9));
    chk("R2 req held 2", int'(rx_req), 1);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R5 last", int'(rx_vec), rxv(12));
    chk("R2 req drops", int'(rx_req), 0);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R6 empty valid", int'(rx_vec_valid), 1);
    chk("R6 empty vec zero", int'(rx_vec), 0);
  endtask

  task automatic t_tx();
    step('0, (N'(1) << 15) | N'(1), '0, '0, '0, 1'b0, 1'b0);
    chk("R1 tx_req", int'(tx_req), 1);
    step('0, '0, '0, '0, '0, 1'b0, 1'b1);
    chk("R4 tx line0", int'(tx_vec), txv(0));
    chk("R10 rx valid quiet", int'(rx_vec_valid), 0);
    step('0, '0, '0, '0, '0, 1'b0, 1'b1);
    chk("R4 tx line15", int'(tx_vec), txv(15));
    chk("R2 tx_req drops", int'(tx_req), 0);
  endtask

  task automatic t_clear();
    step((N'(1) << 2) | (N'(1) << 7), '0, '0, '0, '0, 1'b0, 1'b0);
    step('0, '0, N'(1) << 2, '0, '0, 1'b0, 1'b0);
    chk("R7 no vector on clear", int'(rx_vec_valid), 0);
    chk("R7 other line still pending", int'(rx_req), 1);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R7 cleared line skipped", int'(rx_vec), rxv(7));
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R7 drained", int'(rx_vec), 0);
  endtask

  task automatic t_line_rst();
    step((N'(1) << 4) | (N'(1) << 6), N'(1) << 4, '0, '0, '0, 1'b0, 1'b0);
    step('0, '0, '0, '0, N'(1) << 4, 1'b0, 1'b0);
    chk("R8 tx_req cleared", int'(tx_req), 0);
    step('0, '0, '0, '0, '0, 1'b1, 1'b1);
    chk("R8 rx line4 gone", int'(rx_vec), rxv(6));
    chk("R8 tx empty", int'(tx_vec), 0);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R8 rx drained", int'(rx_vec), 0);
  endtask

  task automatic t_set_wins();
    step(N'(1) << 1, '0, N'(1) << 1, '0, '0, 1'b0, 1'b0);
    chk("R9 set beats clear", int'(rx_req), 1);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R9 set beats clear vec", int'(rx_vec), rxv(1));
    step('0, N'(1) << 2, '0, '0, N'(1) << 2, 1'b0, 1'b0);
    chk("R9 set beats line reset", int'(tx_req), 1);
    step('0, '0, '0, '0, '0, 1'b0, 1'b1);
    chk("R9 line reset vec", int'(tx_vec), txv(2));
    step(N'(1) << 1, '0, '0, '0, '0, 1'b0, 1'b0);
    step(N'(1) << 1, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R9 grant reported", int'(rx_vec), rxv(1));
    chk("R9 set beats grant", int'(rx_req), 1);
    step('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R9 line granted again", int'(rx_vec), rxv(1));
    chk("R9 now empty", int'(rx_req), 0);
  endtask

  task automatic t_both_ack();
    step(N'(1) << 3, N'(1) << 8, '0, '0, '0, 1'b0, 1'b0);
    step('0, '0, '0, '0, '0, 1'b1, 1'b1);
    chk("R10 rx valid", int'(rx_vec_valid), 1);
    chk("R10 tx valid", int'(tx_vec_valid), 1);
    chk("R10 rx vec", int'(rx_vec), rxv(3));
    chk("R10 tx vec", int'(tx_vec), txv(8));
    chk("R10 both empty", int'(rx_req | tx_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_priority();
    t_tx();
    t_clear();
    t_line_rst();
    t_set_wins();
    t_both_ack();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule